// File: doc/BRIEF.md
# Address-Sequence Nonvolatile Command Detector

This block sits beside an asynchronous-style SRAM port. It sees each access as one clock cycle with a valid strobe. For every access it reports the interface mode: deselected, read or write. It also reports whether the data pins would be driven.

It watches for a fixed chain of six consecutive read addresses. The first five addresses are always the same prefix. The sixth address selects the operation: a STORE, which copies the SRAM into shadow memory, or a RECALL, which copies shadow memory back into the SRAM. When a chain completes, the block gives a one-clock start pulse for that operation. It then holds a busy flag for a parameterised number of clocks.

While busy is high, the block ignores new chains and marks every selected access as not serviced. Any access that breaks the chain sends the matcher back to idle, unless that access is itself the first key of the prefix.

Top module: `nvcmd_detector`

## Requirements
- R1: Each access is decoded and shown on `mode` in the cycle after it is sampled. The codes are 2'b00 when ce_n=1 (deselected), 2'b01 when ce_n=0 and we_n=1 (read), and 2'b10 when ce_n=0 and we_n=0 (write). A cycle with no valid access shows 2'b00.
- R2: Six consecutive reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 give a `store_start` pulse. The pulse appears in the cycle after the sixth access and lasts exactly one clock.
- R3: The same five-read prefix followed by 0x0C63 gives a one-clock `recall_start` pulse, with the same timing.
- R4: Address bit 14 and `oe_n` have no effect on whether a chain matches.
- R5: A sixth read of 0x339C, the reserved test chain, starts no operation.
- R6: A write, a deselected access or a read of a wrong address in the middle of a chain aborts the chain. The remaining keys then start nothing.
- R7: An access that breaks the chain and equals 0x0E38 counts as step one of a new chain.
- R8: `busy` rises together with a start pulse. It stays high for exactly STORE_CYCLES clocks after a STORE and RECALL_CYCLES clocks after a RECALL.
- R9: While `busy` is high, complete chains start nothing. Every selected access raises `not_serviced` in the cycle after it.
- R10: `dq_drive` is 1 in the cycle after a read with oe_n=0. It is 0 after writes, after deselected accesses, after reads with oe_n=1, and after the terminal access of a STORE or RECALL chain.
- R11: `store_start` and `recall_start` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | One access is presented this cycle |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Access address; only bits 13:0 are compared |
| mode | output | 2 | Registered mode of the last cycle |
| dq_drive | output | 1 | Data pins would be driven |
| store_start | output | 1 | One-clock STORE start pulse |
| recall_start | output | 1 | One-clock RECALL start pulse |
| busy | output | 1 | Nonvolatile operation in progress |
| not_serviced | output | 1 | The last access came while busy |

## Verification
The hardest state to reach from the ports is a complete, valid chain that arrives while a previous operation is still counting. The bench reaches it by sending a second full STORE chain right after a STORE pulse. It keeps STORE_CYCLES longer than six accesses, so the whole chain lands inside the busy window. The restart rule is reached by breaking a chain at its third access with 0x0E38 and then finishing from the second key onward.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

  typedef enum logic [1:0] {
    MODE_DESEL = 2'b00,
    MODE_READ  = 2'b01,
    MODE_WRITE = 2'b10
  } acc_mode_e;

  localparam int KEY_W      = 14;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  localparam logic [KEY_W-1:0] KEY_STORE  = 14'h0FC0;
  localparam logic [KEY_W-1:0] KEY_RECALL = 14'h0C63;

  // Prefix keys, in the order they must be read
  function automatic logic [KEY_W-1:0] prefix_key(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    prefix_key = 14'h0E38;
      3'd1:    prefix_key = 14'h31C7;
      3'd2:    prefix_key = 14'h03E0;
      3'd3:    prefix_key = 14'h3C1F;
      3'd4:    prefix_key = 14'h303F;
      default: prefix_key = '0;
    endcase
  endfunction

  function automatic acc_mode_e decode_mode(input logic ce_n, input logic we_n);
    if (ce_n)      decode_mode = MODE_DESEL;
    else if (we_n) decode_mode = MODE_READ;
    else           decode_mode = MODE_WRITE;
  endfunction

  // Step taken after an access that breaks the chain
  function automatic logic [STEP_W-1:0] restart_step(input logic is_read,
                                                     input logic [KEY_W-1:0] key);
    restart_step = (is_read && key == prefix_key('0)) ? STEP_W'(1) : '0;
  endfunction

endpackage

// File: rtl/nvcmd_access_decode.sv
module nvcmd_access_decode
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              acc_valid,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_mode_e         acc_mode,
  output logic              is_read,
  output logic              is_sel,
  output logic [KEY_W-1:0]  key
);
  always_comb begin
    acc_mode = acc_valid ? decode_mode(ce_n, we_n) : MODE_DESEL;
    is_read  = (acc_mode == MODE_READ);
    is_sel   = (acc_mode != MODE_DESEL);
    key      = addr[KEY_W-1:0];
  end
endmodule

// File: rtl/nvcmd_seq_matcher.sv
module nvcmd_seq_matcher
  import nvcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             is_read,
  input  logic [KEY_W-1:0] key,
  input  logic             busy,
  output logic             hit_store,
  output logic             hit_recall,
  output logic [STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] step_q, step_d;
  logic              at_terminal;

  assign at_terminal = (step_q == STEP_W'(PREFIX_LEN));
  assign hit_store   = acc_valid && !busy && is_read && at_terminal && key == KEY_STORE;
  assign hit_recall  = acc_valid && !busy && is_read && at_terminal && key == KEY_RECALL;
  assign step_o      = step_q;

  always_comb begin
    step_d = step_q;
    if (busy) begin
      step_d = '0;
    end else if (acc_valid) begin
      if (!at_terminal && is_read && key == prefix_key(step_q))
        step_d = step_q + STEP_W'(1);
      else if (hit_store || hit_recall)
        step_d = '0;
      else
        step_d = restart_step(is_read, key);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  p_step_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(PREFIX_LEN));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(hit_store || hit_recall));

  p_busy_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> step_q == '0);
endmodule

// File: rtl/nvcmd_busy_timer.sv
module nvcmd_busy_timer #(
  parameter int STORE_CYCLES  = 1250000,
  parameter int RECALL_CYCLES = 81250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_store,
  input  logic load_recall,
  output logic busy
);
  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_store)  cnt_q <= CNT_W'(STORE_CYCLES);
    else if (load_recall) cnt_q <= CNT_W'(RECALL_CYCLES);
    else if (busy)        cnt_q <= cnt_q - CNT_W'(1);
  end

  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_store && !load_recall) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_load_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_store |=> cnt_q == CNT_W'(STORE_CYCLES));

  p_load_recall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_recall |=> cnt_q == CNT_W'(RECALL_CYCLES));
endmodule

// File: rtl/nvcmd_detector.sv
module nvcmd_detector
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int STORE_CYCLES  = 1250000,
  parameter int RECALL_CYCLES = 81250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        mode,
  output logic              dq_drive,
  output logic              store_start,
  output logic              recall_start,
  output logic              busy,
  output logic              not_serviced
);
  acc_mode_e         acc_mode;
  logic              is_read, is_sel;
  logic [KEY_W-1:0]  key;
  logic              hit_store, hit_recall;
  logic [STEP_W-1:0] step;

  nvcmd_access_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_valid (acc_valid),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .addr      (addr),
    .acc_mode  (acc_mode),
    .is_read   (is_read),
    .is_sel    (is_sel),
    .key       (key)
  );

  nvcmd_seq_matcher u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .is_read    (is_read),
    .key        (key),
    .busy       (busy),
    .hit_store  (hit_store),
    .hit_recall (hit_recall),
    .step_o     (step)
  );

  nvcmd_busy_timer #(
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_store  (hit_store),
    .load_recall (hit_recall),
    .busy        (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode         <= MODE_DESEL;
      dq_drive     <= 1'b0;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
      not_serviced <= 1'b0;
    end else begin
      mode         <= acc_mode;
      dq_drive     <= is_read && !oe_n && !hit_store && !hit_recall;
      store_start  <= hit_store;
      recall_start <= hit_recall;
      not_serviced <= is_sel && busy;
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_start && recall_start));

  p_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start);

  p_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |=> !recall_start);

  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start || recall_start) |-> (busy && !$past(busy)));

  p_ns_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    not_serviced |-> $past(busy));

  p_drive_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> mode == MODE_READ);
endmodule

// File: tb/nvcmd_detector_tb.sv
module nvcmd_detector_tb;
  localparam int ST_CYC = 40;
  localparam int RC_CYC = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [14:0] addr = '0;
  logic [1:0]  mode;
  logic        dq_drive, store_start, recall_start, busy, not_serviced;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [1:0] r_mode;
  logic r_drv, r_st, r_rc, r_busy, r_ns;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvcmd_detector #(.STORE_CYCLES(ST_CYC), .RECALL_CYCLES(RC_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .mode(mode), .dq_drive(dq_drive),
    .store_start(store_start), .recall_start(recall_start), .busy(busy),
    .not_serviced(not_serviced)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Present one access at a negedge, sample the registered outputs one clock later
  task automatic access(input logic ce, input logic we, input logic oe, input logic [14:0] a);
    ce_n = ce; we_n = we; oe_n = oe; addr = a; acc_valid = 1'b1;
    @(negedge clk);
    r_mode = mode; r_drv = dq_drive; r_st = store_start; r_rc = recall_start;
    r_busy = busy; r_ns = not_serviced;
    acc_valid = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
  endtask

  function automatic logic [13:0] pkey(input int i);
    case (i)
      0: pkey = 14'h0E38; 1: pkey = 14'h31C7; 2: pkey = 14'h03E0;
      3: pkey = 14'h3C1F; default: pkey = 14'h303F;
    endcase
  endfunction

  task automatic prefix(input logic hi, input logic oe);
    for (int i = 0; i < 5; i++) access(1'b0, 1'b1, oe, {hi, pkey(i)});
  endtask

  task automatic idle_until_free();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(mode == 2'b00, "R1", "reset mode", mode, 0);
    check(!store_start && !recall_start, "R11", "reset pulses", store_start, 0);
    check(!busy, "R8", "reset busy", busy, 0);
  endtask

  task automatic t_modes();
    access(1'b1, 1'b1, 1'b0, 15'h0123);
    check(r_mode == 2'b00 && !r_drv, "R1", "deselected mode", r_mode, 0);
    access(1'b0, 1'b1, 1'b0, 15'h0123);
    check(r_mode == 2'b01, "R1", "read mode", r_mode, 1);
    check(r_drv == 1'b1, "R10", "read drive", r_drv, 1);
    access(1'b0, 1'b0, 1'b0, 15'h0123);
    check(r_mode == 2'b10 && !r_drv, "R1", "write mode", r_mode, 2);
    access(1'b0, 1'b1, 1'b1, 15'h0123);
    check(!r_drv, "R10", "read oe high drive", r_drv, 0);
    @(negedge clk);
    check(mode == 2'b00, "R1", "idle cycle mode", mode, 0);
  endtask

  task automatic t_store_and_busy();
    int c0;
    prefix(1'b0, 1'b0);
    access(1'b0, 1'b1, 1'b0, 15'h0FC0);
    c0 = cyc;
    check(r_st && !r_rc, "R2", "store pulse", r_st, 1);
    check(!r_drv, "R10", "terminal cycle drive", r_drv, 0);
    check(r_busy, "R8", "busy with pulse", r_busy, 1);
    // full chain while busy: ignored and flagged
    prefix(1'b0, 1'b0);
    check(r_ns, "R9", "not serviced during busy", r_ns, 1);
    access(1'b0, 1'b1, 1'b0, 15'h0FC0);
    check(!r_st && !r_rc, "R9", "chain ignored while busy", r_st, 0);
    check(!store_start, "R2", "pulse lasted one clock", store_start, 0);
    while (busy) @(negedge clk);
    check(cyc - c0 == ST_CYC, "R8", "store busy length", cyc - c0, ST_CYC);
    access(1'b0, 1'b1, 1'b0, 15'h0001);
    check(!r_ns, "R9", "serviced after busy", r_ns, 1'b0);
  endtask

  task automatic t_recall_hi_oe();
    int c0;
    prefix(1'b1, 1'b1);
    access(1'b0, 1'b1, 1'b1, 15'h4C63);
    c0 = cyc;
    check(r_rc && !r_st, "R3", "recall pulse, A14 and oe_n high", r_rc, 1);
    check(r_rc, "R4", "A14/oe_n ignored", r_rc, 1);
    @(negedge clk);
    check(!recall_start, "R3", "recall one clock", recall_start, 0);
    while (busy) @(negedge clk);
    check(cyc - c0 == RC_CYC, "R8", "recall busy length", cyc - c0, RC_CYC);
  endtask

  task automatic t_reserved();
    prefix(1'b0, 1'b0);
    access(1'b0, 1'b1, 1'b0, 15'h339C);
    check(!r_st && !r_rc && !r_busy, "R5", "reserved terminal", r_st | r_rc, 0);
    check(r_drv, "R10", "reserved terminal drives", r_drv, 1);
  endtask

  task automatic t_abort(input int kind);
    access(1'b0, 1'b1, 1'b0, {1'b0, pkey(0)});
    access(1'b0, 1'b1, 1'b0, {1'b0, pkey(1)});
    case (kind)
      0: access(1'b0, 1'b0, 1'b0, {1'b0, pkey(2)});
      1: access(1'b1, 1'b1, 1'b0, {1'b0, pkey(2)});
      default: access(1'b0, 1'b1, 1'b0, 15'h03E1);
    endcase
    for (int i = 2; i < 5; i++) access(1'b0, 1'b1, 1'b0, {1'b0, pkey(i)});
    access(1'b0, 1'b1, 1'b0, 15'h0FC0);
    check(!r_st && !r_busy, "R6", $sformatf("abort kind %0d", kind), r_st, 0);
  endtask

  task automatic t_restart();
    access(1'b0, 1'b1, 1'b0, {1'b0, pkey(0)});
    access(1'b0, 1'b1, 1'b0, {1'b0, pkey(1)});
    access(1'b0, 1'b1, 1'b0, {1'b0, pkey(0)});
    for (int i = 1; i < 5; i++) access(1'b0, 1'b1, 1'b0, {1'b0, pkey(i)});
    access(1'b0, 1'b1, 1'b0, 15'h0FC0);
    check(r_st, "R7", "restart on first key", r_st, 1);
    idle_until_free();
  endtask

  always @(negedge clk)
    if (store_start && recall_start)
      check(1'b0, "R11", "both pulses", 1, 0);

  initial begin
    #(8 * 20000);
    check(1'b0, "WATCHDOG", "timeout", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_modes();
    t_store_and_busy();
    t_recall_hi_oe();
    t_reserved();
    t_abort(0);
    t_abort(1);
    t_abort(2);
    t_restart();
    finish_run();
  end
endmodule